// File: doc/BRIEF.md
# Clock Distributor Configuration Register Bank

This block stores the settings for a bank of clock output channels and one global control word. Configuration arrives as 32-bit words on a parallel write port: a one-cycle write strobe with a data word. The low nibble of the word is the register address, and the upper bits are split into fields. Addresses 0 to 7 each configure the output channel with the same index. Address 14 holds the controls shared by all channels. Every other address is unused.

Each channel presents four fields to the downstream channel logic: a path-select mode, an output enable, a divider code and a delay-step code. The global word selects the input clock, gates all outputs at once and requests power-down. A write to address 0 with bit 31 set is a software reset. It returns every register to its power-on value, stores nothing else from that word, and leaves no trace of itself, because the reset bit is never stored.

A combinational readback port returns the stored word for any address, so the bank can be inspected through its own interface.

Top module: `clk_dist_cfg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every channel takes its power-on value: mode 0, enable 0, divider code 1 and delay code 0.
- R2: While `rst_n` is low at a rising clock edge, the global register takes its power-on value: input select 1, global output enable 1 and power-down 0.
- R3: A write to channel address k (0 to 7) stores mode from bits 18:17, enable from bit 16, divider code from bits 15:8 and delay code from bits 7:4. The values appear on the channel outputs after that rising edge, and no other channel changes.
- R4: A write to address 14 stores input select from bit 20, global output enable from bit 21 and power-down from bit 22. It changes no channel.
- R5: A write to address 0 with bit 31 set restores every channel and the global register to the values in R1 and R2, and discards all other bits of that word.
- R6: Bit 31 has no reset meaning at channel addresses 1 to 7. The fields of such a word are stored as in R3, and the other registers keep their values.
- R7: Writes to addresses 8 to 13 and 15 change no stored state.
- R8: Readback of a channel address returns the channel fields at the bit positions given in R3, with bits 3:0 equal to the address and all other bits 0. Readback of address 14 returns the fields at the positions given in R4, with bits 3:0 equal to 14. Readback of an unused address returns 0. Bit 31 always reads as 0.
- R9: While `wr_en` is low, no stored field changes, whatever the value on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Write word; bits 3:0 are the address |
| rd_addr | input | 4 | Readback address |
| rd_data | output | 32 | Stored word at `rd_addr` |
| ch_mux | output | 16 | Per-channel path mode, 2 bits per channel |
| ch_en | output | 8 | Per-channel output enable |
| ch_div | output | 64 | Per-channel divider code, 8 bits per channel |
| ch_dly | output | 32 | Per-channel delay code, 4 bits per channel |
| glb_in_sel | output | 1 | Input clock select |
| glb_out_en | output | 1 | Global output enable |
| glb_pwr_down | output | 1 | Power-down request |

## Verification
The bench builds the block with its default parameters: eight channels and the global register at address 14. These values put every address class in reach of the 4-bit address field: the channel range, the single global slot, and the gap of unused addresses on both sides of it (8 to 13 and 15). Field extremes are covered by words with every bit set and every bit clear. The software reset is tested with a word whose other fields are non-zero, and bit 31 is also sent to a channel address other than 0. The hardware reset is applied in the middle of a run, after registers hold non-default values.

// File: rtl/cdr_pkg.sv
// Package: shared field layout, register types and power-on values
// for the clock distributor configuration bank.
// Assumes a 32-bit write word with the register address in bits 3:0.
package cdr_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int MUX_W     = 2;
    localparam int DIV_W     = 8;
    localparam int DLY_W     = 4;

    localparam int DLY_LSB   = 4;
    localparam int DIV_LSB   = 8;
    localparam int EN_BIT    = 16;
    localparam int MUX_LSB   = 17;
    localparam int INSEL_BIT = 20;
    localparam int OUTEN_BIT = 21;
    localparam int PWDN_BIT  = 22;
    localparam int SRST_BIT  = 31;

    typedef struct packed {
        logic [MUX_W-1:0] mux;
        logic             en;
        logic [DIV_W-1:0] div;
        logic [DLY_W-1:0] dly;
    } chan_cfg_t;

    typedef struct packed {
        logic in_sel;
        logic out_en;
        logic pwr_down;
    } glb_cfg_t;

    localparam chan_cfg_t CHAN_DEFAULT = '{mux: '0, en: 1'b0, div: DIV_W'(1), dly: '0};
    localparam glb_cfg_t  GLB_DEFAULT  = '{in_sel: 1'b1, out_en: 1'b1, pwr_down: 1'b0};

    // Extract the channel fields from a write word.
    function automatic chan_cfg_t chan_from_word(input logic [DATA_W-1:0] w);
        chan_cfg_t c;
        c.mux = w[MUX_LSB +: MUX_W];
        c.en  = w[EN_BIT];
        c.div = w[DIV_LSB +: DIV_W];
        c.dly = w[DLY_LSB +: DLY_W];
        return c;
    endfunction

    // Place channel fields and the address back into a word.
    function automatic logic [DATA_W-1:0] chan_to_word(input chan_cfg_t c,
                                                       input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MUX_LSB +: MUX_W] = c.mux;
        w[EN_BIT]           = c.en;
        w[DIV_LSB +: DIV_W] = c.div;
        w[DLY_LSB +: DLY_W] = c.dly;
        w[ADDR_W-1:0]       = a;
        return w;
    endfunction
endpackage

// File: rtl/cdr_wr_decode.sv
// Write decoder: turns the address nibble and the reset bit of a write
// into one write strobe per register plus a software-reset pulse.
// Assumes NUM_CH <= GLB_ADDR, so the global slot never overlaps a channel.
module cdr_wr_decode
    import cdr_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int GLB_ADDR = 14
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_srst,
    output logic [NUM_CH-1:0] ch_we,
    output logic              glb_we,
    output logic              soft_rst,
    output logic              unused_hit
);
    // Software reset exists only at address 0.
    assign soft_rst = wr_en && (wr_addr == '0) && wr_srst;

    genvar k;
    generate
        for (k = 0; k < NUM_CH; k++) begin : g_we
            // Per-channel strobe; a reset word stores nothing.
            assign ch_we[k] = wr_en && (wr_addr == ADDR_W'(k)) && !soft_rst;
        end
    endgenerate

    // Global register strobe.
    assign glb_we = wr_en && (wr_addr == ADDR_W'(GLB_ADDR));

    // Flags a write that lands on no register.
    assign unused_hit = wr_en && !glb_we && (int'(wr_addr) >= NUM_CH);
endmodule

// File: rtl/cdr_chan_reg.sv
// One channel register: holds mode, enable, divider and delay codes.
// Assumes clr and we never target a different word in the same cycle;
// clr wins when both are high.
module cdr_chan_reg
    import cdr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      we,
    input  chan_cfg_t wcfg,
    output chan_cfg_t cfg
);
    // Store the fields, or return to the power-on value on any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cfg <= CHAN_DEFAULT;
        end else if (we) begin
            cfg <= wcfg;
        end
    end

    // R3
    chan_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (cfg == $past(wcfg)));

    // R9
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr) |=> $stable(cfg));
endmodule

// File: rtl/cdr_glb_reg.sv
// Global control register: input select, global output enable, power-down.
// Assumes the same reset priority as the channel registers.
module cdr_glb_reg
    import cdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output glb_cfg_t          cfg
);
    // Store the global fields, or return to the power-on value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cfg <= GLB_DEFAULT;
        end else if (we) begin
            cfg.in_sel   <= wdata[INSEL_BIT];
            cfg.out_en   <= wdata[OUTEN_BIT];
            cfg.pwr_down <= wdata[PWDN_BIT];
        end
    end

    // R4
    glb_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (cfg.pwr_down == $past(wdata[PWDN_BIT]))
                      && (cfg.out_en == $past(wdata[OUTEN_BIT]))
                      && (cfg.in_sel == $past(wdata[INSEL_BIT])));

    // R9
    glb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr) |=> $stable(cfg));
endmodule

// File: rtl/cdr_readback.sv
// Readback mux: rebuilds the stored word for any address.
// The reset bit is never stored, so bit 31 is always 0. Unused addresses read as 0.
module cdr_readback
    import cdr_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int GLB_ADDR = 14
) (
    input  logic [ADDR_W-1:0]            rd_addr,
    input  chan_cfg_t [NUM_CH-1:0]       chans,
    input  glb_cfg_t                     glb,
    output logic [DATA_W-1:0]            rd_data
);
    // Select and repack the addressed register.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (rd_addr == ADDR_W'(k)) begin
                rd_data = chan_to_word(chans[k], rd_addr);
            end
        end
        if (rd_addr == ADDR_W'(GLB_ADDR)) begin
            rd_data[INSEL_BIT]    = glb.in_sel;
            rd_data[OUTEN_BIT]    = glb.out_en;
            rd_data[PWDN_BIT]     = glb.pwr_down;
            rd_data[ADDR_W-1:0]   = rd_addr;
        end
    end
endmodule

// File: rtl/clk_dist_cfg.sv
// Top: configuration register bank for a clock distributor.
// Decodes parallel writes, holds NUM_CH channel registers and one global
// register, drives the flattened fields to the channel logic and offers
// a combinational readback. Synchronous active-low reset.
module clk_dist_cfg
    import cdr_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int GLB_ADDR = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [31:0]             wr_data,
    input  logic [3:0]              rd_addr,
    output logic [31:0]             rd_data,
    output logic [NUM_CH*2-1:0]     ch_mux,
    output logic [NUM_CH-1:0]       ch_en,
    output logic [NUM_CH*8-1:0]     ch_div,
    output logic [NUM_CH*4-1:0]     ch_dly,
    output logic                    glb_in_sel,
    output logic                    glb_out_en,
    output logic                    glb_pwr_down
);
    localparam logic [NUM_CH*DIV_W-1:0] DIV_RST_VEC = {NUM_CH{CHAN_DEFAULT.div}};

    logic [NUM_CH-1:0]       ch_we;
    logic                    glb_we;
    logic                    soft_rst;
    logic                    unused_hit;
    chan_cfg_t               wr_chan;
    chan_cfg_t [NUM_CH-1:0]  chans;
    glb_cfg_t                glb;
    logic                    unused_wr_bits;

    // Bits of the write word that no register keeps.
    assign unused_wr_bits = ^{wr_data[30:23], wr_data[19]};

    assign wr_chan = chan_from_word(wr_data);

    cdr_wr_decode #(.NUM_CH(NUM_CH), .GLB_ADDR(GLB_ADDR)) i_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_data[ADDR_W-1:0]),
        .wr_srst    (wr_data[SRST_BIT]),
        .ch_we      (ch_we),
        .glb_we     (glb_we),
        .soft_rst   (soft_rst),
        .unused_hit (unused_hit)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_CH; k++) begin : g_ch
            cdr_chan_reg i_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (soft_rst),
                .we    (ch_we[k]),
                .wcfg  (wr_chan),
                .cfg   (chans[k])
            );
            assign ch_mux[k*MUX_W +: MUX_W] = chans[k].mux;
            assign ch_en[k]                 = chans[k].en;
            assign ch_div[k*DIV_W +: DIV_W] = chans[k].div;
            assign ch_dly[k*DLY_W +: DLY_W] = chans[k].dly;
        end
    endgenerate

    cdr_glb_reg i_glb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .we    (glb_we),
        .wdata (wr_data),
        .cfg   (glb)
    );

    assign glb_in_sel   = glb.in_sel;
    assign glb_out_en   = glb.out_en;
    assign glb_pwr_down = glb.pwr_down;

    cdr_readback #(.NUM_CH(NUM_CH), .GLB_ADDR(GLB_ADDR)) i_rb (
        .rd_addr (rd_addr),
        .chans   (chans),
        .glb     (glb),
        .rd_data (rd_data)
    );

    // R5
    soft_reset_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3:0] == 4'd0 && wr_data[31]) |=>
            (ch_mux == '0) && (ch_en == '0) && (ch_dly == '0)
            && (ch_div == DIV_RST_VEC)
            && glb_in_sel && glb_out_en && !glb_pwr_down);

    // R7
    unused_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unused_hit |=> $stable(ch_mux) && $stable(ch_en) && $stable(ch_div)
                       && $stable(ch_dly) && $stable(glb_in_sel)
                       && $stable(glb_out_en) && $stable(glb_pwr_down));
endmodule

// File: tb/test_clk_dist_cfg.sv
`timescale 1ns/1ps
module test_clk_dist_cfg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] ch_mux;
    logic [7:0]  ch_en;
    logic [63:0] ch_div;
    logic [31:0] ch_dly;
    logic        glb_in_sel, glb_out_en, glb_pwr_down;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    clk_dist_cfg i_clk_dist_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ch_mux(ch_mux), .ch_en(ch_en),
        .ch_div(ch_div), .ch_dly(ch_dly), .glb_in_sel(glb_in_sel),
        .glb_out_en(glb_out_en), .glb_pwr_down(glb_pwr_down)
    );

    // Vectors: {write word, expected readback at that address}
    localparam logic [63:0] VEC [0:6] = '{
        {32'h0006_A5B0, 32'h0006_A5B0},   // R3 ch0 mode 3, div A5, dly B
        {32'h0001_FF91, 32'h0001_FF91},   // R3 ch1 enabled, div FF
        {32'hFFFF_FFF2, 32'h0007_FFF2},   // R6 bit 31 at ch2 stores fields
        {32'h0002_0037, 32'h0002_0037},   // R3 ch7 mode 1, div 0
        {32'h0050_000E, 32'h0050_000E},   // R4 power-down and input select
        {32'hFFAF_FFFE, 32'h0020_000E},   // R4 only output enable
        {32'h0000_0005, 32'h0000_0005}    // R3 ch5 all zero
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 32'h0BAD_F00D;
    endtask

    task automatic read_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #0.5;
        check(rd_data === exp, req, rd_data, exp);
    endtask

    // Compare the output ports for address a against an expected word.
    task automatic port_chk(input int a, input logic [31:0] exp, input string req);
        logic [31:0] got;
        logic [31:0] want;
        if (a < 8) begin
            got  = {17'd0, ch_mux[a*2 +: 2], ch_en[a], ch_div[a*8 +: 8], ch_dly[a*4 +: 4]};
            want = {17'd0, exp[18:17], exp[16], exp[15:8], exp[7:4]};
        end else begin
            got  = {29'd0, glb_pwr_down, glb_out_en, glb_in_sel};
            want = {29'd0, exp[22:20]};
        end
        check(got === want, req, got, want);
    endtask

    function automatic logic [31:0] dflt(input int a);
        if (a < 8) return 32'h0000_0100 | 32'(a);
        if (a == 14) return 32'h0030_000E;
        return 32'h0;
    endfunction

    task automatic all_defaults(input string req);
        for (int a = 0; a < 16; a++) begin
            read_chk(4'(a), dflt(a), req);
            if (a < 8 || a == 14) port_chk(a, dflt(a), req);
        end
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] snap [16];
        repeat (3) @(negedge clk);
        // R1 R2 R8: state held by reset
        all_defaults("R1/R2 reset state");
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 7; i++) begin
            write_word(VEC[i][63:32]);
            read_chk(VEC[i][35:32], VEC[i][31:0], "R3/R4/R6/R8 table readback");
            port_chk(int'(VEC[i][35:32]), VEC[i][31:0], "R3/R4/R6 table ports");
        end
        // R3 other channels untouched by later writes
        read_chk(4'd0, 32'h0006_A5B0, "R3 ch0 kept");
        read_chk(4'd1, 32'h0001_FF91, "R3 ch1 kept");
        read_chk(4'd3, 32'h0000_0103, "R3 ch3 untouched");
        read_chk(4'd9, 32'h0, "R8 unused reads zero");

        // R7: unused addresses change nothing
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.5;
            snap[a] = rd_data;
        end
        for (int a = 8; a < 16; a++) begin
            if (a != 14) write_word(32'hFFFF_FFF0 | 32'(a));
        end
        for (int a = 0; a < 16; a++) read_chk(4'(a), snap[a], "R7 unused write");

        // R9: data without strobe
        @(negedge clk);
        wr_data = 32'h0007_0001;
        @(negedge clk);
        wr_data = 32'h8000_0000;
        @(negedge clk);
        read_chk(4'd1, snap[1], "R9 no strobe");
        read_chk(4'd0, snap[0], "R9 no strobe reset word");

        // R5: software reset with other fields set
        write_word(32'h8006_A5B0);
        all_defaults("R5 soft reset");
        read_chk(4'd0, 32'h0000_0100, "R5 reset bit not stored");

        // R1 R2: hardware reset mid-run
        write_word(32'h0007_FFF4);
        write_word(32'h0040_000E);
        read_chk(4'd4, 32'h0007_FFF4, "R3 ch4 before hw reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        all_defaults("R1/R2 hw reset mid-run");
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule